// File: doc/BRIEF.md
# Calendar Counter with Masked Alarm

This block is a real-time calendar. A one-second strobe advances seven counters: second, minute, hour, day of month, day of week, month and year. Month is held as 1 to 12. Year is held as a 7-bit count of years since 2000, so it spans 2000 to 2127. Day of month rolls over at the length of the current month, and February takes its leap day in leap years.

Software writes new time and alarm values into holding registers. They take effect only when software writes the commit register. A commit loads only the fields written since the previous commit, so a partial update never drags stale holding values into the live time.

On every strobe the block compares the updated time with the alarm fields. Fields named in the mask register are left out of the comparison. Alarm and tick events are latched in a status register that clears when it is read. They drive an active-low level interrupt. In one-shot mode the alarm disables itself after it fires.

Top module: `calrtc_top`

## Requirements
- R1: After reset, the time reads sec 0, min 0, hour 0, day of month 1, day of week 0, month 1 and year 0. The status, enable and mask registers read 0 and irq_n is high.
- R2: Each strobe adds one second. Seconds wrap 59 to 0 and carry into minutes, minutes wrap 59 to 0 and carry into hours, and hours wrap 23 to 0 and start a new day.
- R3: On a new day, day of month wraps to 1 after day 31, 30, or 28/29. It wraps after 30 in months 4, 6, 9 and 11, and after 31 in the other months except 2. Month 2 has 29 days when the year offset is divisible by 4 and is not 100, and 28 days otherwise. Day of week advances and wraps 6 to 0. Month wraps 12 to 1 and carries into year, and year wraps 127 to 0.
- R4: A write to a time or alarm field has no visible effect until a write to the commit offset 0x78. A commit loads only the fields written since the last commit.
- R5: When a commit and a strobe fall in the same cycle, the time takes the committed values and does not advance. The tick event is still flagged.
- R6: Status bit 1 is set in the cycle after the cycle that follows a strobe, when enable bit 1 is set. It is never set while enable bit 1 is clear.
- R7: Status bit 0 is set only after a strobe, when enable bit 0 is set and every unmasked field of the new time equals the alarm. A commit alone never sets it.
- R8: Mask bit i (register 0x10) removes field i from the alarm comparison. Field order is 0 sec, 1 min, 2 hour, 3 day of month, 4 day of week, 5 month, 6 year.
- R9: With enable bit 2 (one-shot) set, enable bit 0 clears itself when the alarm fires. Without it, enable bit 0 stays set. The enable register (0x08) is written directly, without a commit.
- R10: Reading status (0x04) returns its value one cycle later and clears it. An event that lands in the same cycle as the read is kept.
- R11: irq_n is low exactly while any status bit is set.
- R12: Time fields sit at 0x14 + 4*i and alarm fields at 0x30 + 4*i, with i in the R8 field order. Written values are truncated to the field widths: 6, 6, 5, 5, 3, 4 and 7 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| irq_n | output | 1 | Level interrupt, active low |

## Verification
The assertions take two things for granted:
- tick_1hz is a single-cycle strobe.
- The clear property applies only to reads that coincide with no event.

The counter step properties assume no commit in the strobe cycle, unless that case is deliberately exercised. The stimulus keeps every strobe one cycle wide with idle cycles around it, and it never writes a field in the same cycle as a commit. Field values stay within range, except in the one truncation case. The date sweep loads the last day and the day before it for every month of all 128 years, and predicts the rollover from month length and leap rule computed in the bench.

// File: rtl/calrtc_pkg.sv
package calrtc_pkg;
   localparam int NFLD  = 7;
   localparam int FLD_W = 7;

   localparam int IX_SEC  = 0;
   localparam int IX_MIN  = 1;
   localparam int IX_HOUR = 2;
   localparam int IX_DOM  = 3;
   localparam int IX_DOW  = 4;
   localparam int IX_MON  = 5;
   localparam int IX_YEAR = 6;

   localparam int OFS_STATUS = 'h04;
   localparam int OFS_ENABLE = 'h08;
   localparam int OFS_MASK   = 'h10;
   localparam int OFS_TIME   = 'h14;
   localparam int OFS_ALARM  = 'h30;
   localparam int OFS_COMMIT = 'h78;
   localparam int OFS_STEP   = 4;

   typedef logic [FLD_W-1:0] fld_t;
   typedef logic [NFLD-1:0][FLD_W-1:0] cal_vec_t;

   function automatic int fld_bits(input int i);
      case (i)
         IX_SEC, IX_MIN:  return 6;
         IX_HOUR, IX_DOM: return 5;
         IX_DOW:          return 3;
         IX_MON:          return 4;
         default:         return 7;
      endcase
   endfunction

   function automatic fld_t fld_keep(input int i);
      return fld_t'((1 << fld_bits(i)) - 1);
   endfunction

   function automatic fld_t fld_init(input int i);
      return (i == IX_DOM || i == IX_MON) ? fld_t'(1) : fld_t'(0);
   endfunction
endpackage

// File: rtl/calrtc_shadow.sv
module calrtc_shadow
   import calrtc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NFLD-1:0] wr_stb,
   input  fld_t            wval,
   input  logic            commit,
   output cal_vec_t        shadow,
   output logic [NFLD-1:0] load
);
   logic [NFLD-1:0] dirty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         dirty  <= '0;
      end else begin
         for (int i = 0; i < NFLD; i++) begin
            if (wr_stb[i]) begin
               shadow[i] <= wval & fld_keep(i);
               dirty[i]  <= 1'b1;
            end else if (commit) begin
               dirty[i]  <= 1'b0;
            end
         end
      end
   end

   assign load = dirty & {NFLD{commit}};

   // a commit with no concurrent field write leaves nothing pending
   assert_commit_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !(|wr_stb)) |=> (dirty == '0));
endmodule

// File: rtl/calrtc_counter.sv
module calrtc_counter
   import calrtc_pkg::*;
#(
   parameter bit SKIP_Y100 = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            commit,
   input  logic [NFLD-1:0] load,
   input  cal_vec_t        load_val,
   output cal_vec_t        now
);
   localparam fld_t ONE = fld_t'(1);

   logic     yr_div4, leap;
   fld_t     dim;
   cal_vec_t adv;
   logic     c_sec, c_min, c_hour, c_day, c_mon;

   assign yr_div4 = (now[IX_YEAR][1:0] == 2'b00);

   generate
      if (SKIP_Y100) begin : g_leap_skip
         assign leap = yr_div4 && (now[IX_YEAR] != fld_t'(100));
      end else begin : g_leap_plain
         assign leap = yr_div4;
      end
   endgenerate

   always_comb begin
      case (now[IX_MON])
         fld_t'(2):                                dim = leap ? fld_t'(29) : fld_t'(28);
         fld_t'(4), fld_t'(6), fld_t'(9), fld_t'(11): dim = fld_t'(30);
         default:                                  dim = fld_t'(31);
      endcase
   end

   assign c_sec  = now[IX_SEC]  >= fld_t'(59);
   assign c_min  = c_sec  && (now[IX_MIN]  >= fld_t'(59));
   assign c_hour = c_min  && (now[IX_HOUR] >= fld_t'(23));
   assign c_day  = c_hour && (now[IX_DOM]  >= dim);
   assign c_mon  = c_day  && (now[IX_MON]  >= fld_t'(12));

   always_comb begin
      adv         = now;
      adv[IX_SEC] = c_sec ? '0 : now[IX_SEC] + ONE;
      if (c_sec)  adv[IX_MIN]  = c_min  ? '0 : now[IX_MIN] + ONE;
      if (c_min)  adv[IX_HOUR] = c_hour ? '0 : now[IX_HOUR] + ONE;
      if (c_hour) begin
         adv[IX_DOM] = c_day ? ONE : now[IX_DOM] + ONE;
         adv[IX_DOW] = (now[IX_DOW] >= fld_t'(6)) ? '0 : now[IX_DOW] + ONE;
      end
      if (c_day)  adv[IX_MON]  = c_mon ? ONE : now[IX_MON] + ONE;
      if (c_mon)  adv[IX_YEAR] = now[IX_YEAR] + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NFLD; i++) now[i] <= fld_init(i);
      end else if (commit) begin
         for (int i = 0; i < NFLD; i++) if (load[i]) now[i] <= load_val[i];
      end else if (tick) begin
         now <= adv;
      end
   end

   assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit && now[IX_SEC] < fld_t'(59)) |=> (now[IX_SEC] == $past(now[IX_SEC]) + ONE));
   assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit && c_day) |=> (now[IX_DOM] == ONE));
   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !commit) |=> $stable(now));
endmodule

// File: rtl/calrtc_match.sv
module calrtc_match
   import calrtc_pkg::*;
(
   input  cal_vec_t        now,
   input  cal_vec_t        alarm,
   input  logic [NFLD-1:0] mask,
   output logic            hit
);
   logic [NFLD-1:0] agree;

   generate
      for (genvar gi = 0; gi < NFLD; gi++) begin : g_cmp
         assign agree[gi] = mask[gi] || (now[gi] == alarm[gi]);
      end
   endgenerate

   assign hit = &agree;
endmodule

// File: rtl/calrtc_irq.sv
module calrtc_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_q,
   input  logic       hit,
   input  logic       en_wr,
   input  logic [2:0] en_wval,
   input  logic       st_rd,
   output logic [1:0] status,
   output logic [2:0] enable,
   output logic       irq_n
);
   logic alarm_evt, tick_evt;

   assign alarm_evt = tick_q && hit && enable[0];
   assign tick_evt  = tick_q && enable[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (st_rd ? 2'b00 : status) | {tick_evt, alarm_evt};
         if (en_wr)                       enable    <= en_wval;
         else if (alarm_evt && enable[2]) enable[0] <= 1'b0;
      end
   end

   assign irq_n = ~(|status);

   assert_tick_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_q && enable[1]) |=> status[1]);
   assert_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_q && hit && enable[0] && enable[2] && !en_wr) |=> !enable[0]);
   assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && !tick_q) |=> (status == 2'b00));
   assert_irq_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_q && hit && enable[0]) |=> !irq_n);
endmodule

// File: rtl/calrtc_top.sv
module calrtc_top
   import calrtc_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter bit SKIP_Y100 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_n
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(OFS_COMMIT);

   generate
      if (ADDR_W < 7) begin : g_bad_addr_w
         $error("calrtc_top: ADDR_W too narrow for the commit offset");
      end
      if (DATA_W <= FLD_W) begin : g_bad_data_w
         $error("calrtc_top: DATA_W must exceed the field storage width");
      end
   endgenerate

   logic [NFLD-1:0] wr_time, wr_alarm, tload, aload;
   logic            wr_commit, tick_q, hit;
   cal_vec_t        tshadow, ashadow, now, alarm;
   logic [NFLD-1:0] mask;
   logic [1:0]      status;
   logic [2:0]      enable;
   logic [DATA_W-1:0] rmux;
   fld_t            wval;
   logic            unused_wdata_hi;

   assign wval            = wdata[FLD_W-1:0];
   assign unused_wdata_hi = ^wdata[DATA_W-1:FLD_W];
   assign wr_commit       = wr_en && (addr == A_COMMIT);

   generate
      for (genvar gi = 0; gi < NFLD; gi++) begin : g_dec
         localparam logic [ADDR_W-1:0] A_T = ADDR_W'(OFS_TIME  + OFS_STEP * gi);
         localparam logic [ADDR_W-1:0] A_A = ADDR_W'(OFS_ALARM + OFS_STEP * gi);
         assign wr_time[gi]  = wr_en && (addr == A_T);
         assign wr_alarm[gi] = wr_en && (addr == A_A);
      end
   endgenerate

   calrtc_shadow u_tstage (.clk(clk), .rst_n(rst_n), .wr_stb(wr_time), .wval(wval),
                           .commit(wr_commit), .shadow(tshadow), .load(tload));
   calrtc_shadow u_astage (.clk(clk), .rst_n(rst_n), .wr_stb(wr_alarm), .wval(wval),
                           .commit(wr_commit), .shadow(ashadow), .load(aload));

   calrtc_counter #(.SKIP_Y100(SKIP_Y100)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .commit(wr_commit),
      .load(tload), .load_val(tshadow), .now(now));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm  <= '0;
         mask   <= '0;
         tick_q <= 1'b0;
         rdata  <= '0;
      end else begin
         tick_q <= tick_1hz;
         for (int i = 0; i < NFLD; i++) if (aload[i]) alarm[i] <= ashadow[i];
         if (wr_en && addr == A_MASK) mask <= wdata[NFLD-1:0];
         if (rd_en) rdata <= rmux;
      end
   end

   calrtc_match u_match (.now(now), .alarm(alarm), .mask(mask), .hit(hit));

   calrtc_irq u_irq (
      .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .hit(hit),
      .en_wr(wr_en && addr == A_ENABLE), .en_wval(wdata[2:0]),
      .st_rd(rd_en && addr == A_STATUS),
      .status(status), .enable(enable), .irq_n(irq_n));

   always_comb begin
      rmux = '0;
      if (addr == A_STATUS) rmux[1:0]      = status;
      if (addr == A_ENABLE) rmux[2:0]      = enable;
      if (addr == A_MASK)   rmux[NFLD-1:0] = mask;
      for (int i = 0; i < NFLD; i++) begin
         if (addr == ADDR_W'(OFS_TIME  + OFS_STEP * i)) rmux[FLD_W-1:0] = now[i];
         if (addr == ADDR_W'(OFS_ALARM + OFS_STEP * i)) rmux[FLD_W-1:0] = alarm[i];
      end
   end
endmodule

// File: tb/calrtc_top_test.sv
module calrtc_top_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int TB = 'h14;
   localparam int AB = 'h30;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic irq_n;
   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   calrtc_top #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      addr = AW'(a); wdata = DW'(d); wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      addr = AW'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = int'(rdata);
   endtask

   task automatic tk();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic set_vals(input int base, input int v[7]);
      for (int i = 0; i < 7; i++) wr(base + 4 * i, v[i]);
      wr('h78, 0);
   endtask

   function automatic int bdim(input int m, input int y);
      if (m == 2) return ((y % 4 == 0) && (y != 100)) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: got 0 expected 1 (run incomplete)");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int v;
      int tv[7];
      int av[7];
      int rst_exp[7];
      tv = '{10, 20, 5, 15, 3, 6, 24};
      av = '{11, 20, 5, 15, 3, 6, 24};
      rst_exp = '{0, 0, 0, 1, 0, 1, 0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R1 reset state
      chk("R1 irq_n", int'(irq_n), 1);
      for (int i = 0; i < 7; i++) begin
         rd(TB + 4 * i, v);
         chk("R1 time field", v, rst_exp[i]);
      end
      rd('h04, v); chk("R1 status", v, 0);
      rd('h08, v); chk("R1 enable", v, 0);
      rd('h10, v); chk("R1 mask", v, 0);

      // R12 truncation to field width
      wr(TB, 'hFFFF); wr(TB + 8, 'hFFFF); wr(TB + 16, 'hFFFF); wr('h78, 0);
      rd(TB, v);      chk("R12 sec width", v, 63);
      rd(TB + 8, v);  chk("R12 hour width", v, 31);
      rd(TB + 16, v); chk("R12 dow width", v, 7);

      // R2 clock rollover
      set_vals(TB, '{30, 7, 4, 10, 2, 3, 5});
      tk();
      rd(TB, v);     chk("R2 sec step", v, 31);
      rd(TB + 4, v); chk("R2 min held", v, 7);
      set_vals(TB, '{58, 59, 23, 10, 2, 3, 5});
      tk();
      rd(TB, v);     chk("R2 sec 59", v, 59);
      rd(TB + 8, v); chk("R2 hour held", v, 23);
      tk();
      rd(TB, v);      chk("R2 sec wrap", v, 0);
      rd(TB + 4, v);  chk("R2 min wrap", v, 0);
      rd(TB + 8, v);  chk("R2 hour wrap", v, 0);
      rd(TB + 12, v); chk("R2 day carry", v, 11);
      rd(TB + 16, v); chk("R2 dow carry", v, 3);

      // R5 commit and strobe in one cycle
      wr('h08, 2); rd('h04, v);
      wr(TB, 40);
      addr = AW'('h78); wr_en = 1'b1; tick = 1'b1;
      idle();
      wr_en = 1'b0; tick = 1'b0;
      rd(TB, v); chk("R5 commit wins", v, 40);
      idle();
      rd('h04, v); chk("R5 tick still flagged", v, 2);
      tk();
      rd(TB, v); chk("R5 later advance", v, 41);

      // R4 staging and partial commit
      wr('h08, 0); idle(); idle(); rd('h04, v);
      wr(TB, 7);
      rd(TB, v); chk("R4 not yet visible", v, 41);
      wr('h78, 0);
      rd(TB, v); chk("R4 visible after commit", v, 7);
      tk(); tk();
      wr(TB + 4, 33); wr('h78, 0);
      rd(TB, v);     chk("R4 sec not reloaded", v, 9);
      rd(TB + 4, v); chk("R4 min loaded", v, 33);

      // R6 tick flag
      wr('h08, 2); rd('h04, v);
      tk(); idle();
      chk("R11 irq low on tick", int'(irq_n), 0);
      rd('h04, v); chk("R6 tick flag", v, 2);
      chk("R11 irq high after clear", int'(irq_n), 1);
      wr('h08, 0);
      tk(); idle();
      rd('h04, v); chk("R6 tick disabled", v, 0);
      chk("R11 irq stays high", int'(irq_n), 1);

      // R10 read in the cycle the flag sets
      wr('h08, 2);
      tick = 1'b1; idle();
      tick = 1'b0; addr = AW'('h04); rd_en = 1'b1; idle();
      rd_en = 1'b0; v = int'(rdata);
      chk("R10 old value returned", v, 0);
      rd('h04, v); chk("R10 concurrent event kept", v, 2);
      rd('h04, v); chk("R10 cleared", v, 0);
      wr('h08, 0);

      // R7 alarm and commit-only case
      set_vals(AB, av);
      wr('h08, 1);
      set_vals(TB, av); idle(); idle();
      rd('h04, v); chk("R7 commit alone no alarm", v, 0);
      set_vals(TB, tv); tk(); idle();
      chk("R11 irq low on alarm", int'(irq_n), 0);
      rd('h04, v); chk("R7 alarm fires", v, 1);
      rd('h08, v); chk("R9 enable kept without one-shot", v, 1);

      // R8 per-field mask
      for (int i = 0; i < 7; i++) begin
         int alt[7];
         alt = av;
         alt[i] = av[i] + 1;
         set_vals(AB, alt);
         wr('h10, 1 << i);
         set_vals(TB, tv); tk(); idle();
         rd('h04, v); chk("R8 masked field ignored", v, 1);
         wr('h10, 0);
         set_vals(TB, tv); tk(); idle();
         rd('h04, v); chk("R8 unmasked field blocks", v, 0);
      end
      set_vals(AB, av);

      // R9 one-shot
      wr('h08, 5);
      set_vals(TB, tv); tk(); idle();
      rd('h04, v); chk("R9 one-shot fires", v, 1);
      rd('h08, v); chk("R9 enable self-clears", v, 4);
      set_vals(TB, tv); tk(); idle();
      rd('h04, v); chk("R9 no second alarm", v, 0);
      wr('h08, 0);

      // R3 date rollover over all years and months
      for (int y = 0; y < 128; y++) begin
         for (int m = 1; m <= 12; m++) begin
            int d;
            d = bdim(m, y);
            for (int k = 0; k < 2; k++) begin
               int dw, edom, emon, eyr;
               dw = (y + m + k) % 7;
               set_vals(TB, '{59, 59, 23, d - 1 + k, dw, m, y});
               tk();
               edom = (k == 0) ? d : 1;
               emon = (k == 0) ? m : ((m == 12) ? 1 : m + 1);
               eyr  = (k == 1 && m == 12) ? (y + 1) % 128 : y;
               rd(TB + 12, v); chk("R3 day of month", v, edom);
               rd(TB + 16, v); chk("R3 day of week", v, (dw + 1) % 7);
               rd(TB + 20, v); chk("R3 month", v, emon);
               rd(TB + 24, v); chk("R3 year", v, eyr);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule